// File: doc/BRIEF.md
# Split-Byte Stack Pointer Unit

This block holds a 16-bit stack pointer as two 8-bit registers, one for the upper byte and one for the lower byte. Each register sits at its own fixed location in a 64-entry I/O space, so software reads and writes the pointer one byte at a time. The execution core issues stack operations on a small opcode port. The unit returns the data-memory address or addresses for that access in the same cycle and moves the pointer on the following clock edge.

There are two kinds of stack access. A single-byte data push stores at the current pointer and then steps down by one. A single-byte data pop steps up by one and then reads. Return addresses are two bytes wide. A call or interrupt entry stores the low address byte at the pointer and the high byte one below it, then steps down by two. A return does the mirror image: it reads the high byte one above the pointer and the low byte two above, then steps up by two. A software byte write always wins over a stack operation in the same cycle.

Software must place the stack above address 0x60 before using it. The unit raises a warning output when a push is requested while the pointer is at or below that floor. It does not block the push.

Top module: `stack_ptr_unit`

## Requirements
- R1: After synchronous reset both pointer bytes are 0x00, so `sp_value` reads 0x0000.
- R2: `io_rdata` gives the upper byte when `io_addr` is 0x3E and the lower byte when it is 0x3D, combinationally from the current pointer. Any other address reads 0x00.
- R3: A write (`io_wr`=1) to 0x3E or 0x3D replaces only that byte on the next clock edge. The other byte keeps its value. A write to any other address has no effect on the pointer.
- R4: Opcode 1 (data push): `stk_en`=1, `stk_addr_a`=SP, `stk_two`=0, `stk_addr_b`=0, and the pointer becomes SP-1 on the next edge.
- R5: Opcode 2 (data pop): `stk_en`=1, `stk_addr_a`=SP+1, `stk_two`=0, `stk_addr_b`=0, and the pointer becomes SP+1.
- R6: Opcode 3 (address push for call or interrupt entry): `stk_en`=1, `stk_two`=1, `stk_addr_a`=SP (low byte), `stk_addr_b`=SP-1 (high byte), and the pointer becomes SP-2.
- R7: Opcode 4 (address pop for return): `stk_en`=1, `stk_two`=1, `stk_addr_b`=SP+1 (high byte), `stk_addr_a`=SP+2 (low byte), and the pointer becomes SP+2.
- R8: In a cycle with a write to 0x3E or 0x3D, the opcode is treated as opcode 0. `stk_en`, `stk_two` and `low_warn` are 0, both addresses are 0, and only the written byte changes.
- R9: `low_warn` is 1 exactly when opcode 1 or 3 is accepted while SP <= 0x0060. It stays 0 for pops, for idle cycles and for pushes with SP above 0x0060.
- R10: Pointer arithmetic and access addresses wrap modulo 2^16. For example, a data push at 0x0000 yields 0xFFFF.
- R11: Opcode 0 and the unused opcodes 5 to 7 leave the pointer unchanged, with `stk_en`=0 and both addresses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O location for byte access |
| io_wr | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Byte write data |
| io_rdata | output | 8 | Byte read data for `io_addr` |
| stk_op | input | 3 | Stack opcode: 0 none, 1 data push, 2 data pop, 3 address push, 4 address pop |
| stk_en | output | 1 | A stack memory access happens this cycle |
| stk_two | output | 1 | The access moves two bytes |
| stk_addr_a | output | 16 | Data address of the single byte, or of the low return byte |
| stk_addr_b | output | 16 | Data address of the high return byte (0 for single-byte access) |
| low_warn | output | 1 | A push was requested with the pointer at or below the floor |
| sp_value | output | 16 | Current pointer |

## Verification
The access outputs (`stk_en`, `stk_two`, both addresses, `low_warn`) and `io_rdata` are combinational, so they are due in the same cycle as the opcode or address that produces them. The pointer itself moves one clock edge later. The bench drives every input on the falling edge and compares all outputs one nanosecond later against a behavioural model. The model's pointer is advanced only after the following rising edge, so each registered result is compared exactly one cycle after its stimulus. Runs of pushes down through the 0x60 floor, wrap at both ends of the address range, and collisions between byte writes and opcodes cover the corner cases.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int SP_W   = 16;
    localparam int BYTE_W = 8;
    localparam int NBYTES = SP_W / BYTE_W;

    typedef enum logic [2:0] {
        SOP_NONE  = 3'd0,
        SOP_PUSH1 = 3'd1,
        SOP_POP1  = 3'd2,
        SOP_PUSH2 = 3'd3,
        SOP_POP2  = 3'd4
    } sp_op_e;

    typedef struct packed {
        logic [SP_W-1:0] next_sp;
        logic [SP_W-1:0] addr_a;
        logic [SP_W-1:0] addr_b;
        logic            en;
        logic            two;
        logic            warn;
    } sp_step_t;

    function automatic logic op_is_push(input logic [2:0] op);
        return (op == SOP_PUSH1) || (op == SOP_PUSH2);
    endfunction
endpackage

// File: rtl/sp_io_port.sv
module sp_io_port #(
    parameter int          IO_AW  = 6,
    parameter logic [5:0]  HI_LOC = 6'h3E,
    parameter logic [5:0]  LO_LOC = 6'h3D
) (
    input  logic [IO_AW-1:0]          io_addr,
    input  logic                      io_wr,
    input  logic [sp_pkg::SP_W-1:0]   sp_cur,
    output logic [sp_pkg::NBYTES-1:0] byte_wr,
    output logic                      any_wr,
    output logic [sp_pkg::BYTE_W-1:0] rdata
);
    localparam int BW = sp_pkg::BYTE_W;

    logic hit_hi, hit_lo;

    always_comb begin
        hit_hi  = (io_addr == HI_LOC[IO_AW-1:0]);
        hit_lo  = (io_addr == LO_LOC[IO_AW-1:0]);
        byte_wr = {io_wr & hit_hi, io_wr & hit_lo};
        any_wr  = |byte_wr;
        if (hit_hi)
            rdata = sp_cur[2*BW-1:BW];
        else if (hit_lo)
            rdata = sp_cur[BW-1:0];
        else
            rdata = '0;
    end
endmodule

// File: rtl/sp_arith.sv
module sp_arith #(
    parameter logic [15:0] FLOOR = 16'h0060
) (
    input  logic [2:0]               op,
    input  logic [sp_pkg::SP_W-1:0]  sp_cur,
    output sp_pkg::sp_step_t         step
);
    import sp_pkg::*;

    logic [SP_W-1:0] up1, up2, dn1, dn2;

    always_comb begin
        up1 = sp_cur + SP_W'(1);
        up2 = sp_cur + SP_W'(2);
        dn1 = sp_cur - SP_W'(1);
        dn2 = sp_cur - SP_W'(2);

        step         = '0;
        step.next_sp = sp_cur;
        case (op)
            SOP_PUSH1: begin
                step.en      = 1'b1;
                step.addr_a  = sp_cur;
                step.next_sp = dn1;
            end
            SOP_POP1: begin
                step.en      = 1'b1;
                step.addr_a  = up1;
                step.next_sp = up1;
            end
            SOP_PUSH2: begin
                step.en      = 1'b1;
                step.two     = 1'b1;
                step.addr_a  = sp_cur;
                step.addr_b  = dn1;
                step.next_sp = dn2;
            end
            SOP_POP2: begin
                step.en      = 1'b1;
                step.two     = 1'b1;
                step.addr_b  = up1;
                step.addr_a  = up2;
                step.next_sp = up2;
            end
            default: ;
        endcase
        step.warn = op_is_push(op) && (sp_cur <= FLOOR);
    end
endmodule

// File: rtl/sp_regs.sv
module sp_regs (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [sp_pkg::NBYTES-1:0] byte_wr,
    input  logic                      any_wr,
    input  logic [sp_pkg::BYTE_W-1:0] wdata,
    input  logic                      adv,
    input  logic [sp_pkg::SP_W-1:0]   next_sp,
    output logic [sp_pkg::SP_W-1:0]   sp_cur
);
    localparam int BW = sp_pkg::BYTE_W;

    for (genvar g = 0; g < sp_pkg::NBYTES; g++) begin : g_byte
        logic [BW-1:0] val;
        always_ff @(posedge clk) begin
            if (rst)
                val <= '0;
            else if (any_wr) begin
                if (byte_wr[g])
                    val <= wdata;
            end else if (adv)
                val <= next_sp[g*BW +: BW];
        end
        assign sp_cur[g*BW +: BW] = val;
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
    parameter int          IO_AW  = 6,
    parameter logic [5:0]  HI_LOC = 6'h3E,
    parameter logic [5:0]  LO_LOC = 6'h3D,
    parameter logic [15:0] FLOOR  = 16'h0060
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IO_AW-1:0]          io_addr,
    input  logic                      io_wr,
    input  logic [sp_pkg::BYTE_W-1:0] io_wdata,
    output logic [sp_pkg::BYTE_W-1:0] io_rdata,
    input  logic [2:0]                stk_op,
    output logic                      stk_en,
    output logic                      stk_two,
    output logic [sp_pkg::SP_W-1:0]   stk_addr_a,
    output logic [sp_pkg::SP_W-1:0]   stk_addr_b,
    output logic                      low_warn,
    output logic [sp_pkg::SP_W-1:0]   sp_value
);
    import sp_pkg::*;

    logic [NBYTES-1:0] byte_wr;
    logic              any_wr;
    logic [2:0]        op_eff;
    logic [SP_W-1:0]   sp_cur;
    sp_step_t          step;

    sp_io_port #(.IO_AW(IO_AW), .HI_LOC(HI_LOC), .LO_LOC(LO_LOC)) u_port (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .sp_cur  (sp_cur),
        .byte_wr (byte_wr),
        .any_wr  (any_wr),
        .rdata   (io_rdata)
    );

    // a software byte write cancels the stack operation of the same cycle
    assign op_eff = any_wr ? 3'(SOP_NONE) : stk_op;

    sp_arith #(.FLOOR(FLOOR)) u_arith (
        .op     (op_eff),
        .sp_cur (sp_cur),
        .step   (step)
    );

    sp_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .byte_wr (byte_wr),
        .any_wr  (any_wr),
        .wdata   (io_wdata),
        .adv     (step.en),
        .next_sp (step.next_sp),
        .sp_cur  (sp_cur)
    );

    assign stk_en     = step.en;
    assign stk_two    = step.two;
    assign stk_addr_a = step.addr_a;
    assign stk_addr_b = step.addr_b;
    assign low_warn   = step.warn;
    assign sp_value   = sp_cur;
endmodule

// File: rtl/sp_unit_checker.sv
module sp_unit_checker #(
    parameter int          IO_AW  = 6,
    parameter logic [5:0]  HI_LOC = 6'h3E,
    parameter logic [5:0]  LO_LOC = 6'h3D,
    parameter logic [15:0] FLOOR  = 16'h0060
) (
    input logic             clk,
    input logic             rst,
    input logic [IO_AW-1:0] io_addr,
    input logic             io_wr,
    input logic [7:0]       io_wdata,
    input logic [2:0]       stk_op,
    input logic             stk_en,
    input logic             low_warn,
    input logic [15:0]      sp_value
);
    logic wr_hi, wr_lo, wr_any, quiet;
    assign wr_hi  = io_wr && (io_addr == HI_LOC[IO_AW-1:0]);
    assign wr_lo  = io_wr && (io_addr == LO_LOC[IO_AW-1:0]);
    assign wr_any = wr_hi || wr_lo;
    assign quiet  = !wr_any;

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> sp_value == 16'h0000);

    a_r3_write_hi: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (sp_value[15:8] == $past(io_wdata)) && (sp_value[7:0] == $past(sp_value[7:0])));

    a_r3_write_lo: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (sp_value[7:0] == $past(io_wdata)) && (sp_value[15:8] == $past(sp_value[15:8])));

    a_r4_push1_dec: assert property (@(posedge clk) disable iff (rst)
        (quiet && stk_op == 3'd1) |=> sp_value == $past(sp_value) - 16'd1);

    a_r5_pop1_inc: assert property (@(posedge clk) disable iff (rst)
        (quiet && stk_op == 3'd2) |=> sp_value == $past(sp_value) + 16'd1);

    a_r6_push2_dec: assert property (@(posedge clk) disable iff (rst)
        (quiet && stk_op == 3'd3) |=> sp_value == $past(sp_value) - 16'd2);

    a_r7_pop2_inc: assert property (@(posedge clk) disable iff (rst)
        (quiet && stk_op == 3'd4) |=> sp_value == $past(sp_value) + 16'd2);

    a_r8_write_blocks_access: assert property (@(posedge clk) disable iff (rst)
        wr_any |-> !stk_en && !low_warn);

    a_r9_warn_on_low_push: assert property (@(posedge clk) disable iff (rst)
        (quiet && (stk_op == 3'd1 || stk_op == 3'd3) && sp_value <= FLOOR) |-> low_warn);

    a_r9_no_warn_otherwise: assert property (@(posedge clk) disable iff (rst)
        (stk_op != 3'd1 && stk_op != 3'd3) |-> !low_warn);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (quiet && (stk_op == 3'd0 || stk_op > 3'd4)) |=> $stable(sp_value));
endmodule

bind stack_ptr_unit sp_unit_checker #(
    .IO_AW(IO_AW), .HI_LOC(HI_LOC), .LO_LOC(LO_LOC), .FLOOR(FLOOR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .stk_op   (stk_op),
    .stk_en   (stk_en),
    .low_warn (low_warn),
    .sp_value (sp_value)
);

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [2:0]  stk_op = '0;
    logic        stk_en, stk_two, low_warn;
    logic [15:0] stk_addr_a, stk_addr_b, sp_value;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int msp = 0;

    always #4 clk = ~clk;

    stack_ptr_unit u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .stk_op(stk_op), .stk_en(stk_en), .stk_two(stk_two),
        .stk_addr_a(stk_addr_a), .stk_addr_b(stk_addr_b), .low_warn(low_warn),
        .sp_value(sp_value)
    );

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, compare 1 ns later, advance model after the rising edge
    task automatic step(string tag, int op, bit wr, int addr, int data);
        bit hit;
        int e_rd, e_a, e_b, e_en, e_two, e_warn;
        @(negedge clk);
        stk_op = 3'(op); io_wr = wr; io_addr = 6'(addr); io_wdata = 8'(data);
        #1;
        hit  = wr && (addr == 'h3E || addr == 'h3D);
        e_rd = (addr == 'h3E) ? (msp >> 8) : (addr == 'h3D) ? (msp & 'hFF) : 0;
        e_a = 0; e_b = 0; e_en = 0; e_two = 0; e_warn = 0;
        if (!hit) begin
            case (op)
                1: begin e_en = 1; e_a = msp; end
                2: begin e_en = 1; e_a = (msp + 1) % 65536; end
                3: begin e_en = 1; e_two = 1; e_a = msp; e_b = (msp + 65535) % 65536; end
                4: begin e_en = 1; e_two = 1; e_b = (msp + 1) % 65536; e_a = (msp + 2) % 65536; end
                default: ;
            endcase
            e_warn = (op == 1 || op == 3) && msp <= 'h60;
        end
        chk(tag, "sp_value",   int'(sp_value),   msp);
        chk(tag, "io_rdata",   int'(io_rdata),   e_rd);
        chk(tag, "stk_en",     int'(stk_en),     e_en);
        chk(tag, "stk_two",    int'(stk_two),    e_two);
        chk(tag, "stk_addr_a", int'(stk_addr_a), e_a);
        chk(tag, "stk_addr_b", int'(stk_addr_b), e_b);
        chk(tag, "low_warn",   int'(low_warn),   e_warn);
        @(posedge clk);
        if (hit) begin
            if (addr == 'h3E) msp = (msp & 'hFF) | (data << 8);
            else              msp = (msp & 'hFF00) | data;
        end else begin
            case (op)
                1: msp = (msp + 65535) % 65536;
                2: msp = (msp + 1) % 65536;
                3: msp = (msp + 65534) % 65536;
                4: msp = (msp + 2) % 65536;
                default: ;
            endcase
        end
    endtask

    task automatic set_sp(string tag, int v);
        step(tag, 0, 1, 'h3E, v >> 8);
        step(tag, 0, 1, 'h3D, v & 'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; msp = 0;
        // R1 reset value, R2 byte reads and unmapped read
        step("R1", 0, 0, 'h3E, 0);
        step("R2", 0, 0, 'h3D, 0);
        step("R2", 0, 0, 'h3F, 0);
        // R3 byte-wise writes
        step("R3", 0, 1, 'h3E, 'h12);
        step("R3", 0, 0, 'h3E, 0);
        step("R3", 0, 1, 'h3D, 'h34);
        step("R3", 0, 0, 'h3D, 0);
        step("R3", 0, 1, 'h20, 'hAA);
        step("R2", 0, 0, 'h3E, 0);
        // R4 data pushes, R5 data pops
        for (int i = 0; i < 4; i++) step("R4", 1, 0, 'h3D, 0);
        for (int i = 0; i < 3; i++) step("R5", 2, 0, 'h3D, 0);
        // R6 address push, R7 address pop
        step("R6", 3, 0, 'h3D, 0);
        step("R6", 3, 0, 'h3E, 0);
        step("R7", 4, 0, 'h3D, 0);
        step("R7", 4, 0, 'h3D, 0);
        // R8 software write beats an opcode
        step("R8", 1, 1, 'h3D, 'h80);
        step("R8", 3, 1, 'h3E, 'h00);
        step("R8", 4, 1, 'h3D, 'h50);
        step("R8", 1, 0, 'h3D, 0);
        // R9 warning floor
        set_sp("R9", 'h0062);
        for (int i = 0; i < 4; i++) step("R9", 1, 0, 'h3D, 0);
        step("R9", 3, 0, 'h3D, 0);
        step("R9", 2, 0, 'h3D, 0);
        step("R9", 4, 0, 'h3D, 0);
        step("R9", 0, 0, 'h3D, 0);
        // R10 wrap both ways
        set_sp("R10", 'h0000);
        step("R10", 1, 0, 'h3E, 0);
        step("R10", 2, 0, 'h3E, 0);
        step("R10", 3, 0, 'h3D, 0);
        step("R10", 4, 0, 'h3D, 0);
        set_sp("R10", 'hFFFF);
        step("R10", 4, 0, 'h3D, 0);
        step("R10", 0, 0, 'h3D, 0);
        // R11 idle and unused opcodes
        set_sp("R11", 'h1F00);
        for (int op = 5; op < 8; op++) step("R11", op, 0, 'h3E, 0);
        step("R11", 0, 0, 'h3D, 0);
        // R1 reset again from a non-zero pointer
        @(negedge clk); rst = 1'b1; io_wr = 0; stk_op = 0;
        @(posedge clk); @(negedge clk); rst = 1'b0; msp = 0;
        step("R1", 0, 0, 'h3E, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule